// File: doc/BRIEF.md
# Random Replacement Index Generator

This block picks a pseudo-random entry number for a translation cache whose lowest entries may be locked against replacement. A lock boundary input gives the number of locked entries. Every pick falls between that boundary and the top entry, so a locked entry is never chosen. The source of randomness is a 32-bit linear congruential state. The state advances by one step for each request the block accepts. Its upper 16 bits are then reduced modulo the number of unlocked entries, and the boundary is added back.

The reduction is done by a restoring remainder unit that settles one dividend bit per clock. The block therefore reports busy while a pick is in flight, and it ignores further requests during that time. If the boundary is not below the entry count, no unlocked range exists. In that case the block returns the top entry at once and flags an error instead of dividing by zero.

Top module: `tlb_rand_idx`

## Requirements
- R1: While rst_ni is low and after it is released, the state is 0 and idx_o, valid_o, err_o and busy_o are 0.
- R2: Each accepted request advances the 32-bit state once as state = state × 314159 + 1 (mod 2^32), whatever the path or latency. The first request after reset therefore sees a candidate of 0.
- R3: The candidate is bits 31:16 of the updated state. For a valid range, the result is (candidate mod (NUM_ENTRIES − lock)) + lock, which always lies in [lock, NUM_ENTRIES − 1].
- R4: For a valid range, valid_o is high for one cycle, starting 17 rising edges after the edge that accepts the request. err_o is 0 with that result.
- R5: busy_o is high from the accepting edge until the result is presented. A request made while busy_o is high is ignored and does not advance the state.
- R6: The lock boundary is sampled at the accepting edge. Changes to lock_i during the computation do not affect the result.
- R7: If lock_i ≥ NUM_ENTRIES at acceptance, then at that same edge idx_o becomes NUM_ENTRIES − 1, err_o becomes 1 and valid_o pulses. busy_o stays 0, and the state still advances.
- R8: idx_o and err_o hold their values until the next result, and valid_o is low in the cycle after a normal-path result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request a new index (accepted when busy_o is low) |
| lock_i | input | WIRED_W | Number of locked low entries |
| idx_o | output | WIRED_W | Chosen entry index |
| valid_o | output | 1 | One-cycle pulse when idx_o is updated |
| err_o | output | 1 | Result came from an empty unlocked range |
| busy_o | output | 1 | A remainder computation is in flight |

## Verification
On every cycle, the assertions check the following: a normal result lies inside the unlocked range, and an error result is the top entry. The remainder is below its divisor when it completes, and the outputs hold between results. The state stays frozen unless a step is accepted, and its low bit toggles on every step. The exact index values, the 17-edge latency, the restart of the sequence at reset, and the rule that requests and boundary changes during a busy period are ignored can only be shown by the bench. It sweeps every boundary value, including invalid ones, against an arithmetic model of the generator.

// File: rtl/tlb_rand_pkg.sv
package tlb_rand_pkg;
  localparam int unsigned SEED_W = 32;
  localparam int unsigned CAND_W = 16;
  localparam logic [SEED_W-1:0] LCG_MUL = 32'd314159;
  localparam logic [SEED_W-1:0] LCG_INC = 32'd1;
endpackage

// File: rtl/tlb_lcg_seed.sv
module tlb_lcg_seed
  import tlb_rand_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [CAND_W-1:0] cand_o
);
  logic [SEED_W-1:0] seed_q, seed_nxt;

  assign seed_nxt = seed_q * LCG_MUL + LCG_INC;
  assign cand_o   = seed_nxt[SEED_W-1 -: CAND_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    seed_q <= '0;
    else if (adv_i) seed_q <= seed_nxt;
  end

  AST_SEED_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(seed_q)); // R5
  AST_SEED_LSB_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> seed_q[0] != $past(seed_q[0])); // R2
endmodule

// File: rtl/tlb_mod_seq.sv
module tlb_mod_seq #(
  parameter int unsigned DVD_W = 16,
  parameter int unsigned DVS_W = 7,
  localparam int unsigned CNT_W = $clog2(DVD_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DVD_W-1:0] dividend_i,
  input  logic [DVS_W-1:0] divisor_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DVS_W-1:0] rem_o
);
  logic [DVD_W-1:0] dvd_q;
  logic [DVS_W-1:0] dvs_q, rem_q, rem_nxt;
  logic [DVS_W:0]   trial, diff;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  // restoring step: shift in next dividend bit, subtract if it fits
  always_comb begin
    trial = {rem_q, dvd_q[DVD_W-1]};
    diff  = trial - {1'b0, dvs_q};
    if (trial >= {1'b0, dvs_q}) rem_nxt = diff[DVS_W-1:0];
    else                        rem_nxt = trial[DVS_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dvd_q  <= '0;
      dvs_q  <= '0;
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      dvd_q  <= dividend_i;
      dvs_q  <= divisor_i;
      rem_q  <= '0;
      cnt_q  <= CNT_W'(DVD_W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      rem_q  <= rem_nxt;
      dvd_q  <= dvd_q << 1;
      cnt_q  <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rem_o  = rem_q;

  AST_REM_BELOW_DVS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> rem_q < dvs_q); // R3
  AST_START_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q && !done_q); // R5
  AST_LAST_STEP_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q == CNT_W'(1)) |=> done_q && !busy_q); // R4
endmodule

// File: rtl/tlb_rand_idx.sv
module tlb_rand_idx
  import tlb_rand_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 64,
  parameter int unsigned WIRED_W     = 6,
  localparam int unsigned RNG_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [WIRED_W-1:0] lock_i,
  output logic [WIRED_W-1:0] idx_o,
  output logic               valid_o,
  output logic               err_o,
  output logic               busy_o
);
  localparam logic [WIRED_W:0]   ENT_CMP = (WIRED_W+1)'(NUM_ENTRIES);
  localparam logic [RNG_W-1:0]   ENT_R   = RNG_W'(NUM_ENTRIES);
  localparam logic [WIRED_W-1:0] TOP_IDX = WIRED_W'(NUM_ENTRIES - 1);

  logic [CAND_W-1:0]  cand;
  logic [RNG_W-1:0]   divisor, rem;
  logic [WIRED_W-1:0] lock_q, idx_q;
  logic               accept, range_ok, start, div_busy, div_done;
  logic               valid_q, err_q;

  assign busy_o   = div_busy | div_done;
  assign accept   = req_i & ~busy_o;
  assign range_ok = {1'b0, lock_i} < ENT_CMP;
  assign start    = accept & range_ok;
  assign divisor  = ENT_R - RNG_W'(lock_i);

  tlb_lcg_seed u_seed (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (accept),
    .cand_o (cand)
  );

  tlb_mod_seq #(.DVD_W(CAND_W), .DVS_W(RNG_W)) u_mod (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .dividend_i (cand),
    .divisor_i  (divisor),
    .busy_o     (div_busy),
    .done_o     (div_done),
    .rem_o      (rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (start) lock_q <= lock_i;
      if (div_done) begin
        idx_q   <= lock_q + WIRED_W'(rem);
        err_q   <= 1'b0;
        valid_q <= 1'b1;
      end else if (accept && !range_ok) begin
        idx_q   <= TOP_IDX;
        err_q   <= 1'b1;
        valid_q <= 1'b1;
      end
    end
  end

  assign idx_o   = idx_q;
  assign valid_o = valid_q;
  assign err_o   = err_q;

  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !err_q) |-> (idx_q >= lock_q) && (idx_q <= TOP_IDX)); // R3
  AST_ERR_TOP_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && err_q) |-> idx_q == TOP_IDX); // R7
  AST_ERR_NO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !range_ok) |=> !div_busy); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(idx_q) && $stable(err_q)); // R8
endmodule

// File: tb/tlb_rand_idx_bench.sv
`timescale 1ns/1ps
module tlb_rand_idx_bench;
  localparam int unsigned E = 16;
  localparam int unsigned WW = 6;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic [WW-1:0] lock_v = '0;
  logic [WW-1:0] idx;
  logic valid, err, busy;
  int checks = 0, errors = 0;
  logic [31:0] ms = 32'd0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  tlb_rand_idx #(.NUM_ENTRIES(E), .WIRED_W(WW)) u_tlb_rand_idx (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .lock_i(lock_v),
    .idx_o(idx), .valid_o(valid), .err_o(err), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string r, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic check_reset_state(input string r);
    chk(idx == '0, r, "idx after reset", int'(idx), 0);
    chk(!valid && !err && !busy, r, "flags after reset",
        int'({valid, err, busy}), 0);
  endtask

  // one request; optional poke during busy with another lock value
  task automatic run_req(input int w, input bit poke, input int pw);
    int edges = 0;
    int exp_idx, exp_edges;
    bit exp_err;
    logic [15:0] cand;
    ms = ms * 32'd314159 + 32'd1;
    cand = ms[31:16];
    exp_err = (w >= int'(E));
    exp_idx = exp_err ? int'(E) - 1 : int'(cand) % (int'(E) - w) + w;
    exp_edges = exp_err ? 1 : 18;
    req = 1'b1;
    lock_v = WW'(w);
    while (edges < 40) begin
      @(negedge clk);
      edges++;
      if (edges == 1) req = 1'b0;
      if (poke && edges == 3) begin
        chk(busy == 1'b1, "R5", "busy during computation", int'(busy), 1);
        req = 1'b1;
        lock_v = WW'(pw);
      end
      if (poke && edges == 4) req = 1'b0;
      if (valid) break;
    end
    if (exp_err) chk(busy == 1'b0, "R7", "busy on empty range", int'(busy), 0);
    chk(edges == exp_edges, exp_err ? "R7" : "R4", "result latency", edges, exp_edges);
    chk(int'(idx) == exp_idx, exp_err ? "R7" : (poke ? "R6" : "R3"),
        "index", int'(idx), exp_idx);
    chk(err == exp_err, exp_err ? "R7" : "R4", "err flag", int'(err), int'(exp_err));
    @(negedge clk);
    chk(!valid, "R8", "valid pulse width", int'(valid), 0);
    chk(int'(idx) == exp_idx && err == exp_err, "R8", "result held",
        int'(idx), exp_idx);
  endtask

  initial begin
    #1000000;
    if (!done_flag) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("R1");
    // first pick sees candidate 0: index equals lock
    run_req(5, 1'b0, 0);
    chk(int'(idx) == 5, "R2", "first pick equals lock", int'(idx), 5);
    // sweep all lock values incl. empty range
    for (int w = 0; w < int'(E) + 4; w++)
      for (int k = 0; k < 3; k++) run_req(w, 1'b0, 0);
    // requests and lock changes while busy are ignored
    run_req(3, 1'b1, 12);
    run_req(0, 1'b1, 40);
    run_req(int'(E) - 1, 1'b1, 0);
    run_req(7, 1'b0, 0);
    // empty range still advances state, then normal pick
    run_req(int'(E), 1'b0, 0);
    run_req(2, 1'b0, 0);
    // reset mid-stream restarts the sequence
    rst_n = 1'b0;
    ms = 32'd0;
    @(negedge clk);
    check_reset_state("R1");
    rst_n = 1'b1;
    @(negedge clk);
    run_req(9, 1'b0, 0);
    chk(int'(idx) == 9, "R2", "pick after re-reset", int'(idx), 9);
    for (int k = 0; k < 8; k++) run_req(k % 4, 1'b0, 0);
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule